// File: doc/BRIEF.md
# Configurable Serial Byte Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. Software-side logic writes a byte into a one-entry holding register. When the shift stage is idle, it takes that byte and sends a low start bit, then the data bits least significant first, then an optional parity bit, then one or more high stop bits. Bit timing comes from an oversampling tick supplied from outside: each bit lasts `OVS` ticks (16 by default). A half stop bit lasts `OVS/2` ticks.

A 7-bit format word sets the frame shape: character length from 5 to 8 bits, a short or long stop period, parity on or off, even or odd sense, a forced-constant parity mode, and a break control that pulls the line low. The format is captured when a frame starts. Two status flags report the state of the block: holding register empty, and transmitter completely empty. Because a byte can be written while the previous one is still shifting, frames can be sent back to back.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever nothing is queued or shifting and break is off, `txd` is 1, `thr_empty` is 1 and `tx_empty` is 1.
- R2: A frame is a start bit at 0, then the data bits LSB first, with the count set by `line_ctl[1:0]` (00=5, 01=6, 10=7, 11=8). Data bits above the selected length are not sent. Each bit lasts 16 ticks.
- R3: With `line_ctl[3]`=1, a parity bit follows the data. With `line_ctl[5]`=0, it makes the number of ones even when `line_ctl[4]`=1 and odd when `line_ctl[4]`=0, counting only the data bits sent. With `line_ctl[5]`=1, it is the constant 1 when `line_ctl[4]`=0 and 0 when `line_ctl[4]`=1.
- R4: The stop period is high. With `line_ctl[2]`=0 it lasts 16 ticks. With `line_ctl[2]`=1 it lasts 24 ticks for 5-bit characters and 32 ticks otherwise. `tx_empty` rises on the clock edge that ends it.
- R5: While `line_ctl[6]`=1, `txd` is 0 in every state. Clearing it gives the line back to the frame logic.
- R6: `thr_empty` falls on the edge after a write and rises when the byte moves into the shift stage. A byte written during a frame is sent right after that frame, with one idle clock between the two frames.
- R7: `tx_empty` is 1 only while the holding register is empty and no frame is being shifted.
- R8: Changes to `line_ctl[5:0]` during a frame do not alter that frame.
- R9: With `baud_tick` held low, a frame in progress does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick, OVS per bit |
| line_ctl | input | 7 | Frame format word and break control |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial output line |
| thr_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register empty and shift stage idle |

## Verification
The main function is run with a table of format words covering every character length and every parity mode: odd, even, constant 1 and constant 0. The data bytes are chosen so that each parity sense produces a different bit. Some bytes have set bits above the character length, which shows whether too many data bits are sent. The total frame length, counted from the start edge to `tx_empty`, tells the three stop periods apart and shows whether a parity slot was added. Directed cases cover a second write during a frame, a format change during a frame, break applied while idle and during a frame, and a stalled tick.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W   = 8;
    localparam int MIN_CHAR = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_t;

    // field order mirrors the control word bits 5..0
    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       long_stop;
        logic [1:0] len_sel;
    } frame_fmt_t;

    function automatic logic [3:0] char_bits(input logic [1:0] sel);
        return 4'(MIN_CHAR) + {2'b00, sel};
    endfunction

    function automatic logic parity_of(input frame_fmt_t f, input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] m;
        m = d & DATA_W'((1 << char_bits(f.len_sel)) - 1);
        if (f.stick)
            return !f.even;
        return f.even ? (^m) : ~(^m);
    endfunction

    function automatic int unsigned stop_ticks(input frame_fmt_t f, input int unsigned ovs);
        if (!f.long_stop)
            return ovs;
        if (f.len_sel == 2'b00)
            return ovs + ovs / 2;
        return 2 * ovs;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    assert_write_sets_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (full && data == $past(wr_data)));

    assert_take_needs_full_R6: assert property (@(posedge clk) disable iff (rst)
        take |-> full);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  frame_fmt_t        load_fmt,
    output logic              busy,
    output logic              line
);

    localparam int CNT_W = $clog2(2 * OVS);
    localparam int IDX_W = $clog2(DATA_W);

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sreg;
    frame_fmt_t        fmt;
    logic              par_bit;
    logic              bit_done;
    logic              last_data;

    always_comb begin
        last_cnt  = (phase == PH_STOP) ? CNT_W'(stop_ticks(fmt, OVS) - 1) : CNT_W'(OVS - 1);
        bit_done  = tick && (cnt == last_cnt);
        last_data = (4'(idx) == char_bits(fmt.len_sel) - 4'd1);
        busy      = (phase != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            idx     <= '0;
            sreg    <= '0;
            fmt     <= '0;
            par_bit <= 1'b0;
        end else if (phase == PH_IDLE) begin
            if (load) begin
                phase   <= PH_START;
                cnt     <= '0;
                idx     <= '0;
                sreg    <= load_data;
                fmt     <= load_fmt;
                par_bit <= parity_of(load_fmt, load_data);
            end
        end else if (tick) begin
            if (!bit_done) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                unique case (phase)
                    PH_START: phase <= PH_DATA;
                    PH_DATA: begin
                        sreg <= sreg >> 1;
                        if (last_data)
                            phase <= fmt.par_en ? PH_PARITY : PH_STOP;
                        else
                            idx <= idx + 1'b1;
                    end
                    PH_PARITY: phase <= PH_STOP;
                    default:   phase <= PH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (phase)
            PH_START:  line = 1'b0;
            PH_DATA:   line = sreg[0];
            PH_PARITY: line = par_bit;
            default:   line = 1'b1;
        endcase
    end

    assert_stall_without_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && !tick) |=> ($stable(phase) && $stable(cnt)));

    assert_fmt_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> (phase == PH_IDLE || $stable(fmt)));

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && load) |=> !line);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic [6:0]        line_ctl,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              thr_empty,
    output logic              tx_empty
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              busy;
    logic              line;
    logic              take;
    frame_fmt_t        fmt_in;

    assign fmt_in = frame_fmt_t'(line_ctl[5:0]);
    assign take   = hold_full && !busy;

    sertx_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    sertx_shift #(.OVS(OVS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .load      (take),
        .load_data (hold_data),
        .load_fmt  (fmt_in),
        .busy      (busy),
        .line      (line)
    );

    assign txd       = line_ctl[6] ? 1'b0 : line;
    assign thr_empty = !hold_full;
    assign tx_empty  = !hold_full && !busy;

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !line_ctl[6]) |-> txd);

    assert_empty_order_R7: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> thr_empty);

endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b1;
    logic [6:0] line_ctl = 7'b0000011;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, thr_empty, tx_empty;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sertx_top u0 (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .line_ctl  (line_ctl),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .txd       (txd),
        .thr_empty (thr_empty),
        .tx_empty  (tx_empty)
    );

    // {format word[6:0], data[7:0]}
    localparam logic [14:0] VEC [8] = '{
        {7'b0000011, 8'hA5},
        {7'b0000000, 8'hE0},
        {7'b0001100, 8'h13},
        {7'b0011101, 8'h2C},
        {7'b0101010, 8'h55},
        {7'b0111011, 8'hFF},
        {7'b0001010, 8'h00},
        {7'b0000101, 8'h3F}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [6:0] c);
        int nb, st;
        nb = 5 + c[1:0];
        st = !c[2] ? 16 : (c[1:0] == 2'b00 ? 24 : 32);
        return 16 * (1 + nb + c[3]) + st;
    endfunction

    function automatic logic exp_bit(input logic [6:0] c, input logic [7:0] d, input int k);
        int nb, ones;
        nb = 5 + c[1:0];
        ones = 0;
        if (k == 0) return 1'b0;
        if (k <= nb) return d[k-1];
        for (int i = 0; i < nb; i++) ones += d[i];
        if (c[5]) return !c[4];
        return c[4] ? logic'(ones % 2) : logic'(!(ones % 2));
    endfunction

    task automatic put_byte(input logic [6:0] c, input logic [7:0] d);
        @(negedge clk);
        line_ctl = c;
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start();
        for (int i = 0; i < 10 && txd; i++) @(negedge clk);
    endtask

    task automatic run_frame(input logic [6:0] c, input logic [7:0] d);
        int n, errs, body;
        put_byte(c, d);
        wait_start();
        body = 16 * (1 + 5 + c[1:0] + c[3]);
        n = 0;
        errs = 0;
        while (!tx_empty && n < 400) begin
            @(negedge clk);
            n++;
            if (n % 16 == 8 && n < body && txd != exp_bit(c, d, n / 16)) errs++;
            if (n == body + 4 && txd != 1'b1) errs++;
        end
        check("R2/R3 frame bits", errs, 0);
        check("R4 frame length", n, exp_len(c));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, errs;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 txd", txd, 1);
        check("R1 thr_empty", thr_empty, 1);
        check("R1 tx_empty", tx_empty, 1);

        for (int i = 0; i < 8; i++) run_frame(VEC[i][14:8], VEC[i][7:0]);

        // R5 break while idle
        @(negedge clk);
        line_ctl = 7'b1000011;
        @(negedge clk);
        check("R5 break idle", txd, 0);
        line_ctl = 7'b0000011;
        @(negedge clk);
        check("R5 break released", txd, 1);

        // R5 break during a frame (data all ones)
        put_byte(7'b0000011, 8'hFF);
        wait_start();
        repeat (24) @(negedge clk);
        line_ctl = 7'b1000011;
        @(negedge clk);
        check("R5 break in frame", txd, 0);
        line_ctl = 7'b0000011;
        @(negedge clk);
        check("R5 frame resumes", txd, 1);
        while (!tx_empty) @(negedge clk);

        // R6 / R7 back-to-back bytes, 8N1 frames of 160 ticks
        put_byte(7'b0000011, 8'h81);
        wait_start();
        n = 0;
        while (!tx_empty && n < 800) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                wr_en = 1'b1;
                wr_data = 8'h7E;
            end else begin
                wr_en = 1'b0;
            end
            if (n == 2) begin
                check("R6 queued thr_empty", thr_empty, 0);
                check("R7 busy tx_empty", tx_empty, 0);
            end
            if (n == 160) check("R7 gap tx_empty", tx_empty, 0);
            if (n == 161) begin
                check("R6 moved thr_empty", thr_empty, 1);
                check("R6 second start", txd, 0);
            end
        end
        check("R6 back-to-back length", n, 321);

        // R8 format change mid-frame
        put_byte(7'b0000011, 8'h00);
        wait_start();
        n = 0;
        while (!tx_empty && n < 400) begin
            @(negedge clk);
            n++;
            if (n == 20) line_ctl = 7'b0001100;
        end
        check("R8 format frozen", n, 160);
        line_ctl = 7'b0000011;

        // R9 stalled tick
        @(negedge clk);
        baud_tick = 1'b0;
        put_byte(7'b0000011, 8'hFF);
        wait_start();
        errs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd != 1'b0 || tx_empty) errs++;
        end
        check("R9 no tick no progress", errs, 0);
        baud_tick = 1'b1;
        n = 0;
        while (!tx_empty && n < 400) begin
            @(negedge clk);
            n++;
        end
        check("R1 idle after stall", txd, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule